// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Takeover

An 8-bit general-purpose I/O port. Software sees three byte registers on a simple synchronous bus: an output data register, a direction register and a read-only view of the pin levels. For each pad the block produces separate output value, output enable and input signals, so the pad's tristate buffer sits outside the block.

Several on-chip functions can claim particular pins: a two-wire serial bus controller (clock line on pin 7, data line on pin 6), a UART transmitter (pin 5) and receiver (pin 4), and two DAC channels (pin 1 for channel 1, pin 0 for channel 0). While a function is enabled, that function sets the pin's direction and output value. The stored direction and data bits are left untouched during this time. When the function is disabled, those stored bits take back control of the pin at once.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the data and direction registers read 0x00 and every pad_oe bit is 0.
- R2: The direction register is at offset 1 and can be read and written at any time. A 1 bit makes the pin an output and a 0 bit makes it an input. Bit 2 always reads 0 and ignores writes.
- R3: The data register is at offset 0 and can be read and written. Offset 3 reads 0x00. A write to offset 2 changes neither the data register nor the direction register.
- R4: A pin that no function has claimed has pad_oe equal to its direction bit and pad_out equal to its data bit.
- R5: While i2c_en is 1, pin 7 takes pad_oe/pad_out from i2c_scl_oe/i2c_scl_o, and pin 6 takes them from i2c_sda_oe/i2c_sda_o.
- R6: While uart_tx_en is 1, pin 5 has pad_oe=1 and pad_out=uart_txd.
- R7: While uart_rx_en is 1, pin 4 has pad_oe=0 and pad_out=0.
- R8: While dac_en[1] or dac_en[0] is 1, pin 1 or pin 0 (in that order) has pad_oe=1 and pad_out=0.
- R9: A takeover never changes the stored direction bits. When the function is disabled, the pin again follows its direction and data bits.
- R10: A read at offset 2 returns pad_in as it was two clocks earlier. It passes through a two-flop synchronizer.
- R11: Pin 2 is always an input (pad_oe[2]=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| i2c_en | input | 1 | Two-wire controller enabled |
| i2c_scl_oe | input | 1 | Clock line output enable |
| i2c_scl_o | input | 1 | Clock line output value |
| i2c_sda_oe | input | 1 | Data line output enable |
| i2c_sda_o | input | 1 | Data line output value |
| uart_tx_en | input | 1 | UART transmitter enabled |
| uart_txd | input | 1 | UART transmit data |
| uart_rx_en | input | 1 | UART receiver enabled |
| dac_en | input | 2 | DAC channel enables |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
A wrong direction or data bit shows up on pad_oe or pad_out in the same cycle as the write that stored it, and a register read shows it as well. A takeover that corrupted the stored bits is seen when the function is disabled, on the next read of the direction register. A synchronizer with the wrong depth shows up as a status read that changes one clock too early or one clock too late after pad_in moves.

// File: rtl/gpio_ovr_pkg.sv
// Shared constants for the GPIO port: register offsets, claimed pin
// positions and the implemented-bit mask of the direction register.
package gpio_ovr_pkg;
    localparam int PORT_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int OFS_DATA = 0;
    localparam int OFS_DIR  = 1;
    localparam int OFS_STAT = 2;
    localparam int PIN_SCL  = 7;
    localparam int PIN_SDA  = 6;
    localparam int PIN_TXD  = 5;
    localparam int PIN_RXD  = 4;
    localparam int PIN_DAC1 = 1;
    localparam int PIN_DAC0 = 0;
    localparam logic [PORT_W-1:0] DIR_IMPL = 8'hFB;
endpackage

// File: rtl/gpio_ovr_sync.sv
// Multi-flop synchronizer for the pad inputs.
// Assumes: pad_in is asynchronous to clk; STAGES >= 2.
module gpio_ovr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] chain [STAGES];

    // Purpose: shift the pad levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Purpose: one later stage of the chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
// Register bank: data and direction registers, plus the read mux.
// Assumes: single-cycle accesses; reads are combinational; unmapped
// offsets read zero; DIR_MASK clears the unimplemented direction bits.
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int          W        = PORT_W,
    parameter int          AW       = ADDR_W,
    parameter logic [W-1:0] DIR_MASK = DIR_IMPL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  stat_in,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  dir_q
);
    localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
    localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

    logic wr_en;
    assign wr_en = bus_sel && bus_wr;

    // Purpose: store the data register
    always_ff @(posedge clk) begin
        if (!rst_n)                            data_q <= '0;
        else if (wr_en && bus_addr == A_DATA)  data_q <= bus_wdata;
    end

    // Purpose: store the direction register (implemented bits only)
    always_ff @(posedge clk) begin
        if (!rst_n)                           dir_q <= '0;
        else if (wr_en && bus_addr == A_DIR)  dir_q <= bus_wdata & DIR_MASK;
    end

    // Purpose: select the read data
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                A_DATA:  bus_rdata = data_q;
                A_DIR:   bus_rdata = dir_q;
                A_STAT:  bus_rdata = stat_in;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_ovr_pinmux.sv
// Per-pin owner mux: a claimed pin takes its enable and value from the
// function that claims it; any other pin follows the direction and data bits.
// Assumes: own/p_oe/p_out are already gathered into per-pin vectors.
module gpio_ovr_pinmux #(
    parameter int W = 8
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] p_oe,
    input  logic [W-1:0] p_out,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // Purpose: choose the owner of pin i
        always_comb begin
            pad_oe[i]  = own[i] ? p_oe[i]  : dir_q[i];
            pad_out[i] = own[i] ? p_out[i] : data_q[i];
        end
    end
endmodule

// File: rtl/gpio_port_ovr.sv
// Top of the GPIO port. Gathers the peripheral claims into per-pin
// vectors and wires the register bank, the synchronizer and the pin mux.
// Assumes: peripheral enables are synchronous to clk.
module gpio_port_ovr
    import gpio_ovr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic              i2c_en,
    input  logic              i2c_scl_oe,
    input  logic              i2c_scl_o,
    input  logic              i2c_sda_oe,
    input  logic              i2c_sda_o,
    input  logic              uart_tx_en,
    input  logic              uart_txd,
    input  logic              uart_rx_en,
    input  logic [1:0]        dac_en,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    logic [PORT_W-1:0] data_q, dir_q, stat_q;
    logic [PORT_W-1:0] own, p_oe, p_out;

    // Purpose: collect which function claims each pin and what it drives
    always_comb begin
        own   = '0;
        p_oe  = '0;
        p_out = '0;
        own[PIN_SCL]  = i2c_en;
        p_oe[PIN_SCL] = i2c_scl_oe;
        p_out[PIN_SCL] = i2c_scl_o;
        own[PIN_SDA]  = i2c_en;
        p_oe[PIN_SDA] = i2c_sda_oe;
        p_out[PIN_SDA] = i2c_sda_o;
        own[PIN_TXD]  = uart_tx_en;
        p_oe[PIN_TXD] = 1'b1;
        p_out[PIN_TXD] = uart_txd;
        own[PIN_RXD]  = uart_rx_en;
        own[PIN_DAC1] = dac_en[1];
        p_oe[PIN_DAC1] = 1'b1;
        own[PIN_DAC0] = dac_en[0];
        p_oe[PIN_DAC0] = 1'b1;
    end

    gpio_ovr_regs #(.W(PORT_W), .AW(ADDR_W), .DIR_MASK(DIR_IMPL)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_in(stat_q),
        .bus_rdata(bus_rdata), .data_q(data_q), .dir_q(dir_q)
    );

    gpio_ovr_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(pad_in), .q_out(stat_q)
    );

    gpio_ovr_pinmux #(.W(PORT_W)) mux_i (
        .own(own), .p_oe(p_oe), .p_out(p_out), .dir_q(dir_q),
        .data_q(data_q), .pad_oe(pad_oe), .pad_out(pad_out)
    );
endmodule

// File: rtl/gpio_port_ovr_chk.sv
// Assertion checker for gpio_port_ovr, attached with bind.
// Assumes: two synchronizer stages (the default).
module gpio_port_ovr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       i2c_en,
    input logic       i2c_scl_oe,
    input logic       i2c_scl_o,
    input logic       i2c_sda_oe,
    input logic       i2c_sda_o,
    input logic       uart_tx_en,
    input logic       uart_txd,
    input logic       uart_rx_en,
    input logic [1:0] dac_en,
    input logic [7:0] pad_in,
    input logic [7:0] pad_out,
    input logic [7:0] pad_oe
);
    logic [1:0] since_rst;

    // Purpose: count clocks since reset, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
    end

    assert_i2c_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_en |-> (pad_oe[7] == i2c_scl_oe && pad_out[7] == i2c_scl_o &&
                    pad_oe[6] == i2c_sda_oe && pad_out[6] == i2c_sda_o));
    assert_tx_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uart_tx_en |-> (pad_oe[5] && pad_out[5] == uart_txd));
    assert_rx_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        uart_rx_en |-> (!pad_oe[4] && !pad_out[4]));
    assert_dac1_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_en[1] |-> (pad_oe[1] && !pad_out[1]));
    assert_dac0_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_en[0] |-> (pad_oe[0] && !pad_out[0]));
    assert_pin2_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[2]);
    assert_stat_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2 && bus_sel && !bus_wr && bus_addr == 2'd2)
            |-> bus_rdata == $past(pad_in, 2));
    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd3) |-> bus_rdata == 8'h00);
endmodule

bind gpio_port_ovr gpio_port_ovr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .i2c_en(i2c_en),
    .i2c_scl_oe(i2c_scl_oe), .i2c_scl_o(i2c_scl_o), .i2c_sda_oe(i2c_sda_oe),
    .i2c_sda_o(i2c_sda_o), .uart_tx_en(uart_tx_en), .uart_txd(uart_txd),
    .uart_rx_en(uart_rx_en), .dac_en(dac_en), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_port_ovr_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ovr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       i2c_en = 1'b0;
    logic       i2c_scl_oe = 1'b1, i2c_scl_o = 1'b1;
    logic       i2c_sda_oe = 1'b0, i2c_sda_o = 1'b0;
    logic       uart_tx_en = 1'b0, uart_txd = 1'b0, uart_rx_en = 1'b0;
    logic [1:0] dac_en = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_ovr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .i2c_en(i2c_en), .i2c_scl_oe(i2c_scl_oe), .i2c_scl_o(i2c_scl_o),
        .i2c_sda_oe(i2c_sda_oe), .i2c_sda_o(i2c_sda_o),
        .uart_tx_en(uart_tx_en), .uart_txd(uart_txd), .uart_rx_en(uart_rx_en),
        .dac_en(dac_en), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Vector: {en[4:0] = i2c,tx,rx,dac1,dac0, dir, data, exp_oe, exp_out}
    localparam int NV = 8;
    localparam logic [36:0] VEC [NV] = '{
        {5'b00000, 8'hFF, 8'hA5, 8'hFB, 8'hA5},
        {5'b00000, 8'h00, 8'h5A, 8'h00, 8'h5A},
        {5'b10000, 8'h00, 8'hFF, 8'h80, 8'hBF},
        {5'b01000, 8'h00, 8'hFF, 8'h20, 8'hDF},
        {5'b00100, 8'hFF, 8'hFF, 8'hEB, 8'hEF},
        {5'b00011, 8'h00, 8'hFF, 8'h03, 8'hFC},
        {5'b11111, 8'hFF, 8'h00, 8'hAB, 8'h80},
        {5'b00010, 8'h01, 8'h03, 8'h03, 8'h01}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_en(logic [4:0] en);
        i2c_en = en[4]; uart_tx_en = en[3]; uart_rx_en = en[2]; dac_en = en[1:0];
    endtask

    // Watchdog
    initial begin
        #200us;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        bus_read(2'd0, rd); check("R1 data", rd, 8'h00);
        bus_read(2'd1, rd); check("R1 dir", rd, 8'h00);

        // Table walk: R4..R8, R11; R9 via direction readback under takeover
        for (int v = 0; v < NV; v++) begin
            set_en(5'b0);
            bus_write(2'd0, VEC[v][23:16]);
            bus_write(2'd1, VEC[v][31:24]);
            set_en(VEC[v][36:32]);
            #1;
            check($sformatf("R4-R8 vec%0d oe", v), pad_oe, VEC[v][15:8]);
            check($sformatf("R4-R8 vec%0d out", v), pad_out, VEC[v][7:0]);
            check($sformatf("R11 vec%0d pin2", v), {7'b0, pad_oe[2]}, 8'h00);
            bus_read(2'd1, rd);
            check($sformatf("R9 vec%0d dir kept", v), rd, VEC[v][31:24] & 8'hFB);
        end
        set_en(5'b0);

        // R2: bit 2 unimplemented
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, rd); check("R2 dir mask", rd, 8'hFB);
        bus_write(2'd1, 8'h04);
        bus_read(2'd1, rd); check("R2 bit2 only", rd, 8'h00);

        // R3: data readback, unmapped offset, write to status ignored
        bus_write(2'd0, 8'h3C);
        bus_write(2'd1, 8'h81);
        bus_read(2'd0, rd); check("R3 data", rd, 8'h3C);
        bus_read(2'd3, rd); check("R3 unmapped", rd, 8'h00);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd0, rd); check("R3 data after stat write", rd, 8'h3C);
        bus_read(2'd1, rd); check("R3 dir after stat write", rd, 8'h81);

        // R9: takeover then release returns control to stored bits
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'hC3);
        set_en(5'b10011);
        #1 check("R9 taken oe", pad_oe, 8'h83);
        set_en(5'b00000);
        #1 check("R9 released oe", pad_oe, 8'hC3);
        check("R9 released out", pad_out, 8'h00);

        // R10: status lags pad_in by two clocks
        @(negedge clk);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2;
        pad_in = 8'h5C;
        @(posedge clk); #1 check("R10 after 1 clk", bus_rdata, 8'h00);
        @(posedge clk); #1 check("R10 after 2 clk", bus_rdata, 8'h5C);
        @(negedge clk); bus_sel = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule